// File: doc/BRIEF.md
# SDRAM Command Protocol Monitor

This block watches the command pins of a four-bank single-data-rate synchronous DRAM and reports protocol errors. On every rising clock edge it decodes chip select, the row and column strobes, write enable, the current and previous clock-enable levels, the two bank-select bits and address bit 10. It keeps a record of which banks hold an open row. It also counts, per bank and globally, how many clocks have passed since the events that limit the next command.

When a command breaks a state rule or comes too soon after an earlier one, the monitor raises a one-clock violation flag and a 4-bit code naming the broken rule. All spacings are parameters counted in clocks. The integrator converts nanosecond limits into clocks by dividing by the clock period and rounding up. The command is always applied to the tracked state, whether or not it violated a rule. The monitor never blocks anything; it only observes.

Command encodings use {cs_n, ras_n, cas_n, we_n}: 0000 mode-register load, 0001 refresh, 0011 activate, 0101 read, 0100 write, 0010 precharge, 0110 burst stop, 0111 no-op. A command is decoded only when clock enable was high on the previous edge.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: A cycle with cs_n high, or with the previous clock enable low, is a no-op: it changes no bank state and raises no violation.
- R2: A mode-register load while any bank is open gives code 2. Any non-no-op command fewer than T_MRD clocks after a mode-register load gives code 1, and this check takes priority over every other check.
- R3: Refresh (0001 with clock enable high on both edges) and self-refresh entry (0001 with clock enable falling) give code 3 when any bank is open.
- R4: A read or write to a closed bank gives code 4. An activate to an open bank gives code 5.
- R5: A read or write fewer than T_RCD clocks after the activate of its bank gives code 6.
- R6: A precharge fewer than T_RAS clocks after the activate of an open target bank gives code 7. With a10 high the precharge targets every bank and ba is ignored. Afterwards every bank is closed.
- R7: An activate fewer than T_RP clocks after an explicit precharge of its bank gives code 8.
- R8: Two activates fewer than T_RRD clocks apart, to any banks, give code 9.
- R9: A precharge of a bank fewer than BURST_LEN-1+T_WR clocks after a write to it gives code 10. The last write data arrives BURST_LEN-1 clocks after the write command.
- R10: After a read or write with a10 high (auto-precharge), a read or write issued fewer than BURST_LEN clocks later gives code 11.
- R11: After an auto-precharge the bank is closed. Re-activating it gives code 8 if it comes fewer than BURST_LEN+T_RP clocks after a read, or fewer than BURST_LEN-1+T_WR+T_RP clocks after a write.
- R12: ba values 0, 1, 2 and 3 select banks A, B, C and D for activate, read, write and precharge, and each bank is checked on its own.
- R13: viol_o and code_o are registered. They show the result of the command sampled at a clock edge until the next edge. Code 0 means no violation, and viol_o is high exactly when code_o is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable as seen on the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BANK_BITS | Bank select |
| a10 | input | 1 | Address bit 10: all-bank precharge or auto-precharge |
| viol_o | output | 1 | Violation seen on the last sampled command |
| code_o | output | 4 | Rule broken by that command, 0 when none |

## Verification
The assertions assume the command pins are stable and known at every rising edge after reset. They also assume clock enable stays high except in the single cycle that tests self-refresh entry, because the decoder treats a low previous clock enable as a no-op. The stimulus changes pins only on falling edges and returns the bus to deselect after each command. Each timing sweep starts from a fresh reset, so earlier commands cannot make a later check ambiguous.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [3:0] {
    CMD_NOP, CMD_MRS, CMD_REF, CMD_SREF, CMD_ACT,
    CMD_RD, CMD_WR, CMD_PRE, CMD_BST
  } cmd_e;

  typedef enum logic [3:0] {
    ERR_NONE     = 4'd0,
    ERR_MRD      = 4'd1,
    ERR_MRS_BUSY = 4'd2,
    ERR_REF_BUSY = 4'd3,
    ERR_COL_IDLE = 4'd4,
    ERR_ACT_OPEN = 4'd5,
    ERR_RCD      = 4'd6,
    ERR_RAS      = 4'd7,
    ERR_RP       = 4'd8,
    ERR_RRD      = 4'd9,
    ERR_WR       = 4'd10,
    ERR_AP_LOCK  = 4'd11
  } err_e;

  // A spacing of n clocks becomes a counter loaded with n-1 at the first
  // command; the second command is legal once the counter reads zero.
  function automatic int gap_load(input int n);
    return (n > 1) ? n - 1 : 0;
  endfunction

  // Clocks from a write command to the earliest legal precharge.
  function automatic int wr_recover_clks(input int bl, input int twr);
    return bl - 1 + twr;
  endfunction

  // Clocks from an auto-precharging column command to the next activate.
  function automatic int ap_reopen_clks(input bit is_wr, input int bl,
                                        input int twr, input int trp);
    return is_wr ? (bl - 1 + twr + trp) : (bl + trp);
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
(
  input  logic cke_prev,
  input  logic cke,
  input  logic cs_n,
  input  logic ras_n,
  input  logic cas_n,
  input  logic we_n,
  output cmd_e cmd
);

  always_comb begin
    cmd = CMD_NOP;
    if (cke_prev && !cs_n) begin
      unique case ({ras_n, cas_n, we_n})
        3'b000:  cmd = CMD_MRS;
        3'b001:  cmd = cke ? CMD_REF : CMD_SREF;
        3'b011:  cmd = CMD_ACT;
        3'b101:  cmd = CMD_RD;
        3'b100:  cmd = CMD_WR;
        3'b010:  cmd = CMD_PRE;
        3'b110:  cmd = CMD_BST;
        default: cmd = CMD_NOP;
      endcase
    end
  end

endmodule

// File: rtl/sdram_bank_timer.sv
module sdram_bank_timer
  import sdram_mon_pkg::*;
#(
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4,
  parameter int CW        = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic do_act,
  input  logic do_pre,
  input  logic do_rd,
  input  logic do_wr,
  input  logic auto_pre,
  output logic active,
  output logic rcd_busy,
  output logic ras_busy,
  output logic rp_busy,
  output logic wr_busy
);

  localparam logic [CW-1:0] L_RCD = CW'(gap_load(T_RCD));
  localparam logic [CW-1:0] L_RAS = CW'(gap_load(T_RAS));
  localparam logic [CW-1:0] L_RP  = CW'(gap_load(T_RP));
  localparam logic [CW-1:0] L_WR  = CW'(gap_load(wr_recover_clks(BURST_LEN, T_WR)));
  localparam logic [CW-1:0] L_APR = CW'(gap_load(ap_reopen_clks(1'b0, BURST_LEN, T_WR, T_RP)));
  localparam logic [CW-1:0] L_APW = CW'(gap_load(ap_reopen_clks(1'b1, BURST_LEN, T_WR, T_RP)));

  logic          open_q;
  logic [CW-1:0] rcd_q, ras_q, rp_q, wr_q;

  function automatic logic [CW-1:0] dn(input logic [CW-1:0] v);
    return (v == '0) ? v : v - 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      rcd_q  <= '0;
      ras_q  <= '0;
      rp_q   <= '0;
      wr_q   <= '0;
    end else begin
      rcd_q <= dn(rcd_q);
      ras_q <= dn(ras_q);
      rp_q  <= dn(rp_q);
      wr_q  <= dn(wr_q);
      if (do_act) begin
        open_q <= 1'b1;
        rcd_q  <= L_RCD;
        ras_q  <= L_RAS;
        wr_q   <= '0;
      end else if (do_pre && open_q) begin
        open_q <= 1'b0;
        rp_q   <= L_RP;
      end else if ((do_rd || do_wr) && open_q) begin
        if (do_wr) wr_q <= L_WR;
        if (auto_pre) begin
          open_q <= 1'b0;
          rp_q   <= do_wr ? L_APW : L_APR;
        end
      end
    end
  end

  assign active   = open_q;
  assign rcd_busy = (rcd_q != '0);
  assign ras_busy = (ras_q != '0);
  assign rp_busy  = (rp_q  != '0);
  assign wr_busy  = (wr_q  != '0);

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BANK_BITS = 2,
  parameter int T_RCD     = 2,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 2,
  parameter int T_RRD     = 2,
  parameter int T_MRD     = 2,
  parameter int T_WR      = 2,
  parameter int BURST_LEN = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cke,
  input  logic                 cs_n,
  input  logic                 ras_n,
  input  logic                 cas_n,
  input  logic                 we_n,
  input  logic [BANK_BITS-1:0] ba,
  input  logic                 a10,
  output logic                 viol_o,
  output logic [3:0]           code_o
);

  localparam int NB   = 1 << BANK_BITS;
  localparam int MAXC = BURST_LEN + T_WR + T_RP + T_RAS + T_RCD + T_RRD + T_MRD;
  localparam int CW   = $clog2(MAXC + 1);

  localparam logic [CW-1:0] L_MRD = CW'(gap_load(T_MRD));
  localparam logic [CW-1:0] L_RRD = CW'(gap_load(T_RRD));
  localparam logic [CW-1:0] L_APB = CW'(gap_load(BURST_LEN));

  logic cke_prev;
  cmd_e cmd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_prev <= 1'b1;
    else        cke_prev <= cke;
  end

  sdram_cmd_decode u_dec (
    .cke_prev (cke_prev),
    .cke      (cke),
    .cs_n     (cs_n),
    .ras_n    (ras_n),
    .cas_n    (cas_n),
    .we_n     (we_n),
    .cmd      (cmd)
  );

  // Named decode events, also watched by the checker.
  logic          cmd_live, cmd_act, cmd_col, cmd_pre, cmd_ref;
  logic [NB-1:0] bank_sel, pre_mask;
  logic [NB-1:0] bank_active, rcd_busy, ras_busy, rp_busy, wr_busy;
  logic          sel_active;

  assign cmd_live = (cmd != CMD_NOP);
  assign cmd_act  = (cmd == CMD_ACT);
  assign cmd_col  = (cmd == CMD_RD) || (cmd == CMD_WR);
  assign cmd_pre  = (cmd == CMD_PRE);
  assign cmd_ref  = (cmd == CMD_REF) || (cmd == CMD_SREF);
  assign bank_sel = NB'(1) << ba;
  assign pre_mask = a10 ? {NB{1'b1}} : bank_sel;

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_timer #(
      .T_RCD     (T_RCD),
      .T_RAS     (T_RAS),
      .T_RP      (T_RP),
      .T_WR      (T_WR),
      .BURST_LEN (BURST_LEN),
      .CW        (CW)
    ) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .do_act   (cmd_act && bank_sel[g]),
      .do_pre   (cmd_pre && pre_mask[g]),
      .do_rd    ((cmd == CMD_RD) && bank_sel[g]),
      .do_wr    ((cmd == CMD_WR) && bank_sel[g]),
      .auto_pre (a10),
      .active   (bank_active[g]),
      .rcd_busy (rcd_busy[g]),
      .ras_busy (ras_busy[g]),
      .rp_busy  (rp_busy[g]),
      .wr_busy  (wr_busy[g])
    );
  end

  assign sel_active = |(bank_active & bank_sel);

  // Device-wide spacing counters.
  logic [CW-1:0] mrd_q, rrd_q, apb_q;
  logic          mrd_busy, rrd_busy, apb_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mrd_q <= '0;
      rrd_q <= '0;
      apb_q <= '0;
    end else begin
      mrd_q <= (cmd == CMD_MRS) ? L_MRD : (mrd_busy ? mrd_q - 1'b1 : mrd_q);
      rrd_q <= cmd_act ? L_RRD : (rrd_busy ? rrd_q - 1'b1 : rrd_q);
      apb_q <= (cmd_col && a10 && sel_active) ? L_APB
             : (apb_busy ? apb_q - 1'b1 : apb_q);
    end
  end

  assign mrd_busy = (mrd_q != '0);
  assign rrd_busy = (rrd_q != '0);
  assign apb_busy = (apb_q != '0);

  err_e err_now;

  always_comb begin
    err_now = ERR_NONE;
    if (cmd_live && mrd_busy) begin
      err_now = ERR_MRD;
    end else if (cmd == CMD_MRS) begin
      if (|bank_active) err_now = ERR_MRS_BUSY;
    end else if (cmd_ref) begin
      if (|bank_active) err_now = ERR_REF_BUSY;
    end else if (cmd_act) begin
      if (sel_active)                 err_now = ERR_ACT_OPEN;
      else if (|(rp_busy & bank_sel)) err_now = ERR_RP;
      else if (rrd_busy)              err_now = ERR_RRD;
    end else if (cmd_col) begin
      if (!sel_active)                 err_now = ERR_COL_IDLE;
      else if (apb_busy)               err_now = ERR_AP_LOCK;
      else if (|(rcd_busy & bank_sel)) err_now = ERR_RCD;
    end else if (cmd_pre) begin
      if (|(pre_mask & bank_active & ras_busy))     err_now = ERR_RAS;
      else if (|(pre_mask & bank_active & wr_busy)) err_now = ERR_WR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o <= 1'b0;
      code_o <= ERR_NONE;
    end else begin
      viol_o <= (err_now != ERR_NONE);
      code_o <= err_now;
    end
  end

endmodule

// File: rtl/sdram_cmd_monitor_chk.sv
module sdram_cmd_monitor_chk #(
  parameter int NB = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          a10,
  input logic          cmd_live,
  input logic          cmd_col,
  input logic          cmd_pre,
  input logic          mrd_busy,
  input logic          sel_active,
  input logic [NB-1:0] bank_active,
  input logic          viol_o,
  input logic [3:0]    code_o
);

  assert_flag_code_agree_R13: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o == (code_o != 4'd0));

  assert_deselect_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> !viol_o);

  assert_mode_gap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_live && mrd_busy) |=> (code_o == 4'd1));

  assert_col_to_closed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_col && !sel_active && !mrd_busy) |=> (code_o == 4'd4));

  assert_pre_all_closes_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_pre && a10) |=> (bank_active == '0));

endmodule

bind sdram_cmd_monitor sdram_cmd_monitor_chk #(.NB(NB)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cs_n        (cs_n),
  .a10         (a10),
  .cmd_live    (cmd_live),
  .cmd_col     (cmd_col),
  .cmd_pre     (cmd_pre),
  .mrd_busy    (mrd_busy),
  .sel_active  (sel_active),
  .bank_active (bank_active),
  .viol_o      (viol_o),
  .code_o      (code_o)
);

// File: tb/sdram_cmd_monitor_bench.sv
module sdram_cmd_monitor_bench;

  localparam int BL = 4, TRCD = 2, TRAS = 5, TRP = 2, TRRD = 2, TMRD = 2, TWR = 2;

  localparam logic [3:0] C_MRS = 4'b0000, C_REF = 4'b0001, C_ACT = 4'b0011,
                         C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                         C_NOP = 4'b0111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = 2'd0;
  logic a10 = 1'b0;
  logic viol_o;
  logic [3:0] code_o;

  int total = 0;
  int bad = 0;
  logic got_v;
  logic [3:0] got_c;

  always #10 clk = ~clk;

  sdram_cmd_monitor #(
    .BANK_BITS(2), .T_RCD(TRCD), .T_RAS(TRAS), .T_RP(TRP), .T_RRD(TRRD),
    .T_MRD(TMRD), .T_WR(TWR), .BURST_LEN(BL)
  ) u_sdram_cmd_monitor (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .viol_o(viol_o), .code_o(code_o)
  );

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; cs_n = 1'b1; cke = 1'b1;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // One command per clock: driven at a falling edge, result read at the next.
  task automatic send(input logic [3:0] c, input logic [1:0] b, input logic ap,
                      input logic ck);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b; a10 = ap; cke = ck;
    @(posedge clk);
    @(negedge clk);
    got_v = viol_o; got_c = code_o;
    {cs_n, ras_n, cas_n, we_n} = 4'b1111;
    a10 = 1'b0; cke = 1'b1;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(C_NOP, 2'd0, 1'b0, 1'b1);
  endtask

  task automatic chk(input int exp, input string tag);
    total++;
    if (got_c !== 4'(exp) || got_v !== (exp != 0)) begin
      bad++;
      $display("FAIL %s: got viol=%0b code=%0d, expected viol=%0b code=%0d",
               tag, got_v, got_c, (exp != 0), exp);
    end
  endtask

  initial begin
    do_reset();
    got_v = viol_o; got_c = code_o;
    chk(0, "R13 reset state");

    // R1: a deselected cycle shaped like an activate leaves bank A closed
    do_reset();
    send(4'b1011, 2'd0, 1'b0, 1'b1);
    chk(0, "R1 deselect quiet");
    send(C_RD, 2'd0, 1'b0, 1'b1);
    chk(4, "R1 deselect no state");
    idle(1);
    chk(0, "R13 flag clears");

    // R5 and R12: activate to read spacing, swept over every bank
    for (int b = 0; b < 4; b++)
      for (int j = 1; j <= 3; j++) begin
        do_reset();
        send(C_ACT, 2'(b), 1'b0, 1'b1);
        idle(j - 1);
        send(C_RD, 2'(b), 1'b0, 1'b1);
        chk((j < TRCD) ? 6 : 0, $sformatf("R5 R12 bank=%0d gap=%0d", b, j));
      end

    // R6: activate to precharge, single bank
    for (int j = 1; j <= 6; j++) begin
      do_reset();
      send(C_ACT, 2'd0, 1'b0, 1'b1);
      idle(j - 1);
      send(C_PRE, 2'd0, 1'b0, 1'b1);
      chk((j < TRAS) ? 7 : 0, $sformatf("R6 gap=%0d", j));
    end

    // R6: all-bank precharge ignores ba and closes every bank
    for (int j = 1; j <= 6; j++) begin
      do_reset();
      send(C_ACT, 2'd1, 1'b0, 1'b1);
      idle(6);
      send(C_ACT, 2'd2, 1'b0, 1'b1);
      idle(j - 1);
      send(C_PRE, 2'd0, 1'b1, 1'b1);
      chk((j < TRAS) ? 7 : 0, $sformatf("R6 all-bank gap=%0d", j));
      send(C_RD, 2'd1, 1'b0, 1'b1);
      chk(4, "R6 all banks closed");
    end

    // R7: precharge to activate, same bank
    for (int j = 1; j <= 3; j++) begin
      do_reset();
      send(C_ACT, 2'd3, 1'b0, 1'b1);
      idle(TRAS);
      send(C_PRE, 2'd3, 1'b0, 1'b1);
      idle(j - 1);
      send(C_ACT, 2'd3, 1'b0, 1'b1);
      chk((j < TRP) ? 8 : 0, $sformatf("R7 gap=%0d", j));
    end

    // R8: activate to activate across banks
    for (int j = 1; j <= 3; j++) begin
      do_reset();
      send(C_ACT, 2'd0, 1'b0, 1'b1);
      idle(j - 1);
      send(C_ACT, 2'd1, 1'b0, 1'b1);
      chk((j < TRRD) ? 9 : 0, $sformatf("R8 gap=%0d", j));
    end

    // R9: write to precharge
    for (int j = 1; j <= 6; j++) begin
      do_reset();
      send(C_ACT, 2'd2, 1'b0, 1'b1);
      idle(5);
      send(C_WR, 2'd2, 1'b0, 1'b1);
      idle(j - 1);
      send(C_PRE, 2'd2, 1'b0, 1'b1);
      chk((j < BL - 1 + TWR) ? 10 : 0, $sformatf("R9 gap=%0d", j));
    end

    // R10: column command during an auto-precharge burst
    for (int j = 1; j <= 5; j++) begin
      do_reset();
      send(C_ACT, 2'd0, 1'b0, 1'b1);
      idle(1);
      send(C_ACT, 2'd1, 1'b0, 1'b1);
      idle(2);
      send(C_RD, 2'd0, 1'b1, 1'b1);
      idle(j - 1);
      send(C_RD, 2'd1, 1'b0, 1'b1);
      chk((j < BL) ? 11 : 0, $sformatf("R10 gap=%0d", j));
    end

    // R11: reopening after auto-precharge read and write
    for (int w = 0; w < 2; w++)
      for (int j = 1; j <= 8; j++) begin
        do_reset();
        send(C_ACT, 2'd1, 1'b0, 1'b1);
        idle(2);
        send(w ? C_WR : C_RD, 2'd1, 1'b1, 1'b1);
        idle(j - 1);
        send(C_ACT, 2'd1, 1'b0, 1'b1);
        chk((j < (w ? BL - 1 + TWR + TRP : BL + TRP)) ? 8 : 0,
            $sformatf("R11 write=%0d gap=%0d", w, j));
      end

    // R4: column command to closed banks, activate to open bank
    do_reset();
    send(C_RD, 2'd2, 1'b0, 1'b1);
    chk(4, "R4 read closed");
    send(C_WR, 2'd3, 1'b0, 1'b1);
    chk(4, "R4 write closed");
    send(C_ACT, 2'd1, 1'b0, 1'b1);
    idle(6);
    send(C_ACT, 2'd1, 1'b0, 1'b1);
    chk(5, "R4 activate open");

    // R2: mode load while open, and command spacing after a mode load
    do_reset();
    send(C_ACT, 2'd0, 1'b0, 1'b1);
    idle(3);
    send(C_MRS, 2'd0, 1'b0, 1'b1);
    chk(2, "R2 mode load open");
    for (int j = 1; j <= 3; j++) begin
      do_reset();
      send(C_MRS, 2'd0, 1'b0, 1'b1);
      chk(0, "R2 mode load idle");
      idle(j - 1);
      send(C_ACT, 2'd0, 1'b0, 1'b1);
      chk((j < TMRD) ? 1 : 0, $sformatf("R2 gap=%0d", j));
    end

    // R3: refresh and self-refresh entry
    do_reset();
    send(C_REF, 2'd0, 1'b0, 1'b1);
    chk(0, "R3 refresh idle");
    send(C_ACT, 2'd3, 1'b0, 1'b1);
    idle(3);
    send(C_REF, 2'd0, 1'b0, 1'b1);
    chk(3, "R3 refresh open");
    do_reset();
    send(C_ACT, 2'd0, 1'b0, 1'b1);
    idle(3);
    send(C_REF, 2'd0, 1'b0, 1'b0);
    chk(3, "R3 self-refresh open");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got hung run, expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule